// File: doc/BRIEF.md
# Parallel FIFO Bridge Write Controller

This block drives the write half of an external byte-wide FIFO bridge chip, the kind that moves bytes between an FPGA and a host link. Logic inside the chip offers one byte at a time through a valid/ready handshake. The controller accepts a byte only when the external chip reports free transmit space. That report comes in on an active-low flag, which the block re-times through a two-flop synchronizer.

After it accepts a byte, the controller drives the byte onto a dedicated write bus and raises the write strobe. The strobe stays high for a minimum pulse width and then goes low. The strobe is then held low for a minimum recovery time before the space flag is sampled again. By the end of that recovery time the chip has already withdrawn the flag, so the controller waits cleanly for the next free slot.

The write bus comes with an output-enable. A tristate wrapper at the top level uses the two to drive the shared bidirectional pins. Both timing windows are whole clock cycles, computed from the clock period. Each one is the minimum time in nanoseconds divided by the period, rounded up, and never less than one cycle.

Top module: `fifo_bridge_wr`

## Requirements
- R1: While a synchronous reset is asserted, and on the first cycle after it, `wr`, `data_oe` and `in_ready` are all low.
- R2: `in_ready` is high only when the controller is idle and the synchronized space flag is low. Suppose `space_n` is low at rising edge k and stays low, and the controller is idle. Then `in_ready` is still low after edge k and is high after edge k+1.
- R3: The byte on `data_in` at the handshake edge (`in_valid` and `in_ready` both high) is captured. It appears on `data_out` from the next cycle and stays unchanged for as long as `wr` is high.
- R4: `wr` rises in the cycle after the handshake edge. It stays high for exactly PULSE_CYC consecutive cycles, where PULSE_CYC = max(1, ceil(PULSE_MIN_NS / CLK_PERIOD_NS)). This is 5 cycles at the defaults (10 ns clock, 50 ns minimum).
- R5: `data_oe` is high in exactly the cycles in which `wr` is high.
- R6: After `wr` falls, `wr` and `in_ready` both stay low for exactly RECOVER_CYC cycles. RECOVER_CYC = max(1, ceil(RECOVER_MIN_NS / CLK_PERIOD_NS)), which is 5 at the defaults. If `space_n` is held low, `in_ready` rises in the cycle after those RECOVER_CYC cycles.
- R7: While the synchronized space flag is high, no write starts and holding `in_valid` high has no effect.
- R8: `in_valid` is ignored while `in_ready` is low: no new byte is captured and `data_out` keeps the last captured byte.
- R9: When the recovery time ends and `space_n` is high, the controller stays idle with `in_ready` low for as long as the flag stays high. It resumes the R2 timing once the flag goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| data_in | input | DATA_W (8) | Byte offered by internal logic |
| in_valid | input | 1 | Byte on `data_in` is valid |
| in_ready | output | 1 | Controller accepts a byte this cycle |
| space_n | input | 1 | External chip transmit-space flag, active low, asynchronous |
| wr | output | 1 | Write strobe to external chip, active high |
| data_out | output | DATA_W (8) | Write data toward the tristate wrapper |
| data_oe | output | 1 | Output-enable for the shared data pins |

## Verification
The bench measures the exact width of the strobe and the exact length of the recovery gap. A timer that is off by one in either direction shows up as a strobe or gap of 4 or 6 cycles, or as a controller that restarts before the external chip has cleared its flag. It checks the two-edge synchronizer latency, so a design that reads the raw flag or adds a third stage is caught one cycle early or late. It changes `data_in` and pulses `in_valid` during a strobe, and it raises the flag during recovery. A design that captures outside the handshake, or that returns to writing after recovery without polling the flag, changes the bus or strobes into a full FIFO. A reset in the middle of the strobe must drop `wr` and `data_oe` at once.

// File: rtl/fifo_bridge_pkg.sv
package fifo_bridge_pkg;

    typedef enum logic [1:0] {
        ST_POLL    = 2'd0,
        ST_STROBE  = 2'd1,
        ST_RECOVER = 2'd2
    } wr_state_e;

    // Whole cycles covering a minimum time, never fewer than one.
    function automatic int cycles_for(input int min_ns, input int period_ns);
        int c;
        c = (min_ns + period_ns - 1) / period_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/bridge_flag_sync.sv
module bridge_flag_sync #(
    parameter int STAGES    = 2,
    parameter bit RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_d;
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = async_in;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], async_in};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) chain_q <= {STAGES{RESET_VAL}};
        else     chain_q <= chain_d;
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/bridge_cycle_timer.sv
module bridge_cycle_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

    // R4/R6 windows rest on the counter settling at zero once it gets there
    p_zero_sticks_r6: assert property (@(posedge clk) disable iff (rst)
        (expired && !load) |=> expired)
        else $error("timer left zero without a load");

    p_load_taken_r4: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt_q == $past(load_val)))
        else $error("timer did not take load value");
endmodule

// File: rtl/bridge_wr_fsm.sv
module bridge_wr_fsm
    import fifo_bridge_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int PULSE_CYC   = 5,
    parameter int RECOVER_CYC = 5,
    parameter int CNT_W       = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] data_in,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              space_sync_n,
    input  logic              tmr_expired,
    output logic              tmr_load,
    output logic [CNT_W-1:0]  tmr_val,
    output logic              wr,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe
);
    localparam logic [CNT_W-1:0] PULSE_LD   = CNT_W'(PULSE_CYC - 1);
    localparam logic [CNT_W-1:0] RECOVER_LD = CNT_W'(RECOVER_CYC - 1);

    typedef struct packed {
        wr_state_e         st;
        logic [DATA_W-1:0] byte_v;
        logic              wr;
        logic              oe;
    } fsm_regs_t;

    fsm_regs_t regs_d;
    fsm_regs_t regs_q;
    logic      take_d;

    always_comb begin
        regs_d   = regs_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        take_d   = (regs_q.st == ST_POLL) && !space_sync_n && in_valid;
        unique case (regs_q.st)
            ST_POLL: begin
                if (take_d) begin
                    regs_d.byte_v = data_in;
                    regs_d.st     = ST_STROBE;
                    regs_d.wr     = 1'b1;
                    regs_d.oe     = 1'b1;
                    tmr_load      = 1'b1;
                    tmr_val       = PULSE_LD;
                end
            end
            ST_STROBE: begin
                if (tmr_expired) begin
                    regs_d.st = ST_RECOVER;
                    regs_d.wr = 1'b0;
                    regs_d.oe = 1'b0;
                    tmr_load  = 1'b1;
                    tmr_val   = RECOVER_LD;
                end
            end
            ST_RECOVER: begin
                if (tmr_expired)
                    regs_d.st = ST_POLL;
            end
            default: begin
                regs_d.st = ST_POLL;
                regs_d.wr = 1'b0;
                regs_d.oe = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q.st     <= ST_POLL;
            regs_q.byte_v <= '0;
            regs_q.wr     <= 1'b0;
            regs_q.oe     <= 1'b0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign in_ready = (regs_q.st == ST_POLL) && !space_sync_n;
    assign wr       = regs_q.wr;
    assign data_oe  = regs_q.oe;
    assign data_out = regs_q.byte_v;

    // Run-length counter for checking the strobe width (R4)
    logic [CNT_W:0] wr_run_q;
    always_ff @(posedge clk) begin
        if (rst || !wr) wr_run_q <= '0;
        else            wr_run_q <= wr_run_q + 1'b1;
    end

    p_pulse_width_r4: assert property (@(posedge clk) disable iff (rst)
        (!wr && wr_run_q != '0) |-> (wr_run_q == (CNT_W+1)'(PULSE_CYC)))
        else $error("strobe width differs from PULSE_CYC");

    p_start_after_handshake_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> wr)
        else $error("handshake did not start strobe");

    p_bus_stable_r3: assert property (@(posedge clk) disable iff (rst)
        (wr && $past(wr)) |-> $stable(data_out))
        else $error("data bus moved during strobe");

    p_capture_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (data_out == $past(data_in)))
        else $error("captured byte mismatch");

    p_no_capture_r8: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && in_ready) |=> $stable(data_out))
        else $error("byte changed without handshake");

    p_ready_idle_only_r2: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> (!wr && !data_oe))
        else $error("ready during a write");
endmodule

// File: rtl/fifo_bridge_wr.sv
module fifo_bridge_wr
    import fifo_bridge_pkg::*;
#(
    parameter int DATA_W         = 8,
    parameter int CLK_PERIOD_NS  = 10,
    parameter int PULSE_MIN_NS   = 50,
    parameter int RECOVER_MIN_NS = 50,
    parameter int SYNC_STAGES    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] data_in,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              space_n,
    output logic              wr,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe
);
    localparam int PULSE_CYC   = cycles_for(PULSE_MIN_NS, CLK_PERIOD_NS);
    localparam int RECOVER_CYC = cycles_for(RECOVER_MIN_NS, CLK_PERIOD_NS);
    localparam int LONGEST     = max_of(PULSE_CYC, RECOVER_CYC);
    localparam int CNT_W       = max_of(1, $clog2(LONGEST + 1));

    logic             space_sync_n;
    logic             tmr_expired;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;

    bridge_flag_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (space_n),
        .sync_out (space_sync_n)
    );

    bridge_cycle_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    bridge_wr_fsm #(
        .DATA_W      (DATA_W),
        .PULSE_CYC   (PULSE_CYC),
        .RECOVER_CYC (RECOVER_CYC),
        .CNT_W       (CNT_W)
    ) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .data_in      (data_in),
        .in_valid     (in_valid),
        .in_ready     (in_ready),
        .space_sync_n (space_sync_n),
        .tmr_expired  (tmr_expired),
        .tmr_load     (tmr_load),
        .tmr_val      (tmr_val),
        .wr           (wr),
        .data_out     (data_out),
        .data_oe      (data_oe)
    );

    p_oe_tracks_wr_r5: assert property (@(posedge clk) disable iff (rst)
        data_oe == wr)
        else $error("output enable and strobe disagree");

    p_gap_after_fall_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(wr) |-> !in_ready)
        else $error("ready right after strobe fell");

    p_flag_blocks_r7: assert property (@(posedge clk) disable iff (rst)
        space_sync_n |-> !in_ready)
        else $error("ready while no space");
endmodule

// File: tb/sim_fifo_bridge_wr.sv
`timescale 1ns/1ps
module sim_fifo_bridge_wr;
    localparam int PER     = 10;
    localparam int EXP_HI  = (50 + PER - 1) / PER;
    localparam int EXP_REC = (50 + PER - 1) / PER;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] data_in = 8'h00;
    logic       in_valid = 1'b0;
    logic       space_n = 1'b1;
    logic       in_ready, wr, data_oe;
    logic [7:0] data_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(PER/2) clk = ~clk;

    fifo_bridge_wr u0 (
        .clk(clk), .rst(rst), .data_in(data_in), .in_valid(in_valid),
        .in_ready(in_ready), .space_n(space_n), .wr(wr),
        .data_out(data_out), .data_oe(data_oe)
    );

    // {byte, idle gap cycles}
    localparam logic [11:0] VEC [0:7] = '{
        12'h5A0, 12'hA53, 12'h001, 12'hFF7,
        12'h810, 12'h7E2, 12'h3C5, 12'hC30
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_byte(input logic [7:0] b, output int hi,
                              output int rec, output int bad);
        int w;
        w = 0; bad = 0;
        while (!in_ready && w < 50) begin @(negedge clk); w++; end
        data_in = b; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        hi = 0;
        while (wr && hi < 100) begin
            if (data_out !== b || data_oe !== 1'b1) bad++;
            hi++;
            @(negedge clk);
        end
        rec = 0;
        while (!in_ready && rec < 100) begin
            if (wr || data_oe) bad++;
            rec++;
            @(negedge clk);
        end
    endtask

    initial begin
        int hi, rec, bad;
        @(negedge clk); @(negedge clk);
        // R1: during reset
        chk("R1 wr in reset", wr, 0);
        chk("R1 oe in reset", data_oe, 0);
        chk("R1 ready in reset", in_ready, 0);
        space_n = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        chk("R1 ready first cycle after reset", in_ready, 0);
        chk("R1 wr first cycle after reset", wr, 0);

        // Vector table walk: R3, R4, R5, R6
        for (int i = 0; i < 8; i++) begin
            repeat (VEC[i][3:0]) @(negedge clk);
            write_byte(VEC[i][11:4], hi, rec, bad);
            chk($sformatf("R4 strobe width vec%0d", i), hi, EXP_HI);
            chk($sformatf("R6 recovery gap vec%0d", i), rec, EXP_REC);
            chk($sformatf("R3 R5 bus/oe during strobe vec%0d", i), bad, 0);
            chk($sformatf("R3 byte held after vec%0d", i), data_out, VEC[i][11:4]);
        end

        // R7: flag high blocks writes even with in_valid held
        space_n = 1'b1;
        repeat (3) @(negedge clk);
        data_in = 8'h99; in_valid = 1'b1;
        bad = 0;
        for (int k = 0; k < 20; k++) begin
            if (wr || in_ready || data_oe) bad++;
            @(negedge clk);
        end
        chk("R7 no write while flag high", bad, 0);
        in_valid = 1'b0;

        // R2: synchronizer latency
        @(negedge clk);
        space_n = 1'b0;
        @(negedge clk);
        chk("R2 ready after one edge", in_ready, 0);
        @(negedge clk);
        chk("R2 ready after two edges", in_ready, 1);

        // R8: in_valid and new data during strobe ignored
        data_in = 8'h42; in_valid = 1'b1;
        @(negedge clk);
        data_in = 8'hBD;
        bad = 0;
        for (int k = 0; k < EXP_HI - 1; k++) begin
            @(negedge clk);
            if (data_out !== 8'h42) bad++;
        end
        in_valid = 1'b0;
        chk("R8 bus unchanged by in_valid in strobe", bad, 0);
        @(negedge clk);
        chk("R8 strobe over", wr, 0);

        // R9: flag rises during recovery, controller keeps waiting
        space_n = 1'b1;
        bad = 0;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (in_ready || wr) bad++;
        end
        chk("R9 stays idle while flag high", bad, 0);
        chk("R8 byte still last captured", data_out, 8'h42);
        space_n = 1'b0;
        @(negedge clk);
        chk("R9 resume after one edge", in_ready, 0);
        @(negedge clk);
        chk("R9 resume after two edges", in_ready, 1);

        // R1: reset in the middle of a strobe
        data_in = 8'h66; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        chk("R4 strobe running before reset", wr, 1);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 wr dropped by reset", wr, 0);
        chk("R1 oe dropped by reset", data_oe, 0);
        chk("R1 ready low in reset", in_ready, 0);
        rst = 1'b0;
        @(negedge clk); @(negedge clk);
        chk("R2 ready after reset release", in_ready, 1);
        write_byte(8'hE1, hi, rec, bad);
        chk("R4 width after reset", hi, EXP_HI);
        chk("R6 gap after reset", rec, EXP_REC);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule